// File: doc/BRIEF.md
# Programmable PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches two single-cycle strobes that are synchronous to a fast sampling clock: one marks each edge of the divided reference, the other each edge of the divided feedback. For every pairing of a reference strobe with its feedback strobe it counts the sampling ticks between them. The reference side sets the phase. Either strobe may arrive first.

A two-bit select picks the largest phase error still counted as good, from four widths that are not evenly spaced. An eight-bit target sets how many good comparisons in a row are needed before lock is declared. The first bad comparison, or any cycle slip, drops lock at once. The lock flag drives an output pin. An identical status copy is offered for a register file.

Top module: `ld_lock_detect`

## Requirements
- R1: While rst_ni is low, lock_o and lock_stat_o are 0. After reset the active window is select code 00.
- R2: The phase error is the number of clock edges from the first strobe of a pair to the second, whichever input leads. Strobes sampled on the same edge give error 0, which is always in-window.
- R3: Window select codes map to maximum errors in ticks: 00 → 2, 01 → 5, 10 → 7, 11 → 20. An error equal to the maximum is in-window.
- R4: When the second strobe is still missing after the maximum error has elapsed, the comparison is out-of-window. On that edge lock_o goes to 0, without waiting for the late strobe.
- R5: A cycle slip clears lock_o at the edge where it is sampled. A slip is a second strobe on one input before the other input has produced its strobe.
- R6: lock_o goes to 1 on the edge that completes the N-th consecutive in-window comparison, where N is lock_tgt_i. A target of 0 behaves like 1.
- R7: The consecutive-good count saturates at lock_tgt_i and clears on any violation. If the target is raised after saturation, the next good comparison is counted from the saturated value.
- R8: window_sel_i is taken on each reference strobe, and that value governs the comparison then in progress. A change of window_sel_i or lock_tgt_i on its own leaves lock_o unchanged until the next comparison completes.
- R9: lock_stat_o always equals lock_o.
- R10: A strobe that arrives after its pair has timed out is absorbed. It does not start a new comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference-divider edge strobe, one cycle wide |
| fb_i | input | 1 | Feedback-divider edge strobe, one cycle wide |
| window_sel_i | input | 2 | Phase-error window select |
| lock_tgt_i | input | 8 | Consecutive in-window comparisons required for lock |
| lock_o | output | 1 | 1 = locked, 0 = unlocked |
| lock_stat_o | output | 1 | Status copy of lock_o |

## Verification
Every window code is tried with reference-first and feedback-first pairs at exactly the maximum error and one tick beyond it. This separates an off-by-one in the measurement from a swapped table entry or a direction-dependent count.

Coincident strobes show that a zero error is accepted. Back-to-back strobes on one input show that a slip is detected even though no timeout has occurred. A late strobe followed by a clean pair shows whether the late strobe wrongly opened a new comparison.

Changing the select in the middle of a comparison separates "applied at the next reference edge" from "applied at once". Raising the target after saturation separates a saturating count from a free-running one.

// File: rtl/ld_pkg.sv
package ld_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_FB,
    ST_WAIT_REF,
    ST_LATE_FB,
    ST_LATE_REF
  } ph_st_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/ld_win_sel.sv
module ld_win_sel #(
  parameter int unsigned WIN0  = 2,
  parameter int unsigned WIN1  = 5,
  parameter int unsigned WIN2  = 7,
  parameter int unsigned WIN3  = 20,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] lim_o
);
  localparam int unsigned SEL_N = 1 << SEL_W;
  localparam int unsigned TAB [4] = '{WIN0, WIN1, WIN2, WIN3};

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] lut [SEL_N];

  for (genvar g = 0; g < SEL_N; g++) begin : g_lut
    assign lut[g] = CNT_W'(TAB[g % 4]);
  end

  // window latched on every reference strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= '0;
    else if (ref_i) sel_q <= sel_i;
  end

  assign lim_o = lut[sel_q];
endmodule

// File: rtl/ld_phase_meas.sv
module ld_phase_meas
  import ld_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             fb_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             good_o,
  output logic             bad_o,
  output logic [CNT_W-1:0] cnt_o
);
  ph_st_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = '0;
    good_o = 1'b0;
    bad_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_i && fb_i) good_o = 1'b1;
        else if (ref_i) begin st_d = ST_WAIT_FB;  cnt_d = CNT_W'(1); end
        else if (fb_i)  begin st_d = ST_WAIT_REF; cnt_d = CNT_W'(1); end
      end
      ST_WAIT_FB: begin
        if (fb_i) begin
          good_o = 1'b1;
          if (ref_i) begin st_d = ST_WAIT_FB; cnt_d = CNT_W'(1); end
          else st_d = ST_IDLE;
        end else if (ref_i) begin
          bad_o = 1'b1;                    // slip: restart from newer edge
          cnt_d = CNT_W'(1);
        end else if (cnt_q >= lim_i) begin
          bad_o = 1'b1;
          st_d  = ST_LATE_FB;
        end else cnt_d = cnt_q + CNT_W'(1);
      end
      ST_WAIT_REF: begin
        if (ref_i) begin
          good_o = 1'b1;
          if (fb_i) begin st_d = ST_WAIT_REF; cnt_d = CNT_W'(1); end
          else st_d = ST_IDLE;
        end else if (fb_i) begin
          bad_o = 1'b1;
          cnt_d = CNT_W'(1);
        end else if (cnt_q >= lim_i) begin
          bad_o = 1'b1;
          st_d  = ST_LATE_REF;
        end else cnt_d = cnt_q + CNT_W'(1);
      end
      ST_LATE_FB: begin
        if (fb_i) begin
          if (ref_i) begin st_d = ST_WAIT_FB; cnt_d = CNT_W'(1); end
          else st_d = ST_IDLE;
        end else if (ref_i) bad_o = 1'b1;
      end
      ST_LATE_REF: begin
        if (ref_i) begin
          if (fb_i) begin st_d = ST_WAIT_REF; cnt_d = CNT_W'(1); end
          else st_d = ST_IDLE;
        end else if (fb_i) bad_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ld_lock_ctr.sv
module ld_lock_ctr #(
  parameter int unsigned TGT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             good_i,
  input  logic             bad_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic             lock_o
);
  logic [TGT_W-1:0] ok_q, ok_inc;
  logic             lock_q;

  assign ok_inc = (ok_q < tgt_i) ? ok_q + TGT_W'(1) : ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q   <= '0;
      lock_q <= 1'b0;
    end else if (bad_i) begin
      ok_q   <= '0;
      lock_q <= 1'b0;
    end else if (good_i) begin
      ok_q   <= ok_inc;
      lock_q <= (ok_inc >= tgt_i);
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/ld_lock_detect.sv
module ld_lock_detect #(
  parameter int unsigned WIN0  = 2,
  parameter int unsigned WIN1  = 5,
  parameter int unsigned WIN2  = 7,
  parameter int unsigned WIN3  = 20,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned TGT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             fb_i,
  input  logic [SEL_W-1:0] window_sel_i,
  input  logic [TGT_W-1:0] lock_tgt_i,
  output logic             lock_o,
  output logic             lock_stat_o
);
  localparam int unsigned WIN_MAX = ld_pkg::max4(WIN0, WIN1, WIN2, WIN3);
  localparam int unsigned CNT_W   = $clog2(WIN_MAX + 1);

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt;
  logic             res_good, res_bad;
  logic             lock;

  ld_win_sel #(
    .WIN0(WIN0), .WIN1(WIN1), .WIN2(WIN2), .WIN3(WIN3),
    .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i),
    .sel_i(window_sel_i), .lim_o(lim)
  );

  ld_phase_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i),
    .lim_i(lim), .good_o(res_good), .bad_o(res_bad), .cnt_o(cnt)
  );

  ld_lock_ctr #(.TGT_W(TGT_W)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .good_i(res_good), .bad_i(res_bad),
    .tgt_i(lock_tgt_i), .lock_o(lock)
  );

  assign lock_o      = lock;
  assign lock_stat_o = lock;
endmodule

// File: rtl/ld_lock_detect_chk.sv
module ld_lock_detect_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             res_good,
  input logic             res_bad,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim,
  input logic             lock_o
);
  assert_bad_unlocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_bad |=> !lock_o);

  assert_lock_needs_good_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(res_good));

  assert_hold_no_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_good || res_bad) |=> $stable(lock_o));

  assert_err_in_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= lim);

  assert_one_verdict_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({res_good, res_bad}));
endmodule

bind ld_lock_detect ld_lock_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .res_good(res_good), .res_bad(res_bad),
  .cnt(cnt), .lim(lim), .lock_o(lock_o)
);

// File: tb/sim_ld_lock_detect.sv
`timescale 1ns/1ps
module sim_ld_lock_detect;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_i = 1'b0;
  logic       fb_i = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [7:0] tgt = 8'd1;
  logic       lock_o, lock_stat_o;
  int         n_run = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  ld_lock_detect u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i),
    .window_sel_i(sel), .lock_tgt_i(tgt),
    .lock_o(lock_o), .lock_stat_o(lock_stat_o)
  );

  function automatic int win_of(input logic [1:0] s);
    case (s)
      2'b00: return 2;
      2'b01: return 5;
      2'b10: return 7;
      default: return 20;
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic f);
    ref_i = r; fb_i = f;
    @(posedge clk); #2;
    ref_i = 1'b0; fb_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  task automatic pair(input int d, input logic fb_first);
    if (d == 0) step(1'b1, 1'b1);
    else begin
      step(!fb_first, fb_first);
      if (d > 1) idle(d - 1);
      step(fb_first, !fb_first);
    end
    idle(2);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(posedge clk); #2;
    @(posedge clk); #2;
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #3;
    check(lock_o, 1'b0, "R1 lock in reset");
    check(lock_stat_o, 1'b0, "R1 status in reset");
    do_reset();
    check(lock_o, 1'b0, "R1 lock after reset");
  endtask

  task automatic t_acquire();
    do_reset(); sel = 2'b00; tgt = 8'd4;
    for (int i = 0; i < 3; i++) pair(1, 1'b0);
    check(lock_o, 1'b0, "R6 three of four good");
    pair(1, 1'b1);
    check(lock_o, 1'b1, "R6 fourth good locks");
    check(lock_stat_o, 1'b1, "R9 status mirrors lock");
  endtask

  task automatic t_windows();
    for (int s = 0; s < 4; s++) begin
      int w;
      do_reset(); sel = 2'(s); tgt = 8'd1; w = win_of(2'(s));
      pair(0, 1'b0);
      check(lock_o, 1'b1, "R2 zero error locks");
      pair(w, 1'b0);
      check(lock_o, 1'b1, "R3 ref-first at window edge");
      pair(w + 1, 1'b0);
      check(lock_o, 1'b0, "R4 ref-first one past window");
      check(lock_stat_o, 1'b0, "R9 status after drop");
      pair(w, 1'b1);
      check(lock_o, 1'b1, "R3 fb-first at window edge");
      pair(w + 1, 1'b1);
      check(lock_o, 1'b0, "R4 fb-first one past window");
    end
  endtask

  task automatic t_timeout();
    do_reset(); sel = 2'b00; tgt = 8'd1;
    pair(1, 1'b0);
    step(1'b1, 1'b0);
    idle(1);
    check(lock_o, 1'b1, "R4 lock held inside window");
    idle(1);
    check(lock_o, 1'b0, "R4 drop before late edge");
    step(1'b0, 1'b1);
    idle(3);
    pair(1, 1'b0);
    check(lock_o, 1'b1, "R10 late edge absorbed");
  endtask

  task automatic t_slip();
    do_reset(); sel = 2'b01; tgt = 8'd1;
    pair(1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check(lock_o, 1'b0, "R5 double reference slip");
    step(1'b0, 1'b1); idle(2);
    check(lock_o, 1'b1, "R5 recovers after ref slip");
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    check(lock_o, 1'b0, "R5 double feedback slip");
    step(1'b1, 1'b0); idle(2);
    check(lock_o, 1'b1, "R5 recovers after fb slip");
  endtask

  task automatic t_sel_change();
    do_reset(); sel = 2'b00; tgt = 8'd1;
    pair(1, 1'b0);
    sel = 2'b11;
    idle(3);
    check(lock_o, 1'b1, "R8 select change keeps lock");
    pair(2, 1'b0);
    pair(15, 1'b0);
    check(lock_o, 1'b1, "R8 new wide window active");
    step(1'b1, 1'b0);
    sel = 2'b00;
    idle(9);
    step(1'b0, 1'b1); idle(2);
    check(lock_o, 1'b1, "R8 window held from ref edge");
    pair(3, 1'b0);
    check(lock_o, 1'b0, "R8 narrow window after next ref");
  endtask

  task automatic t_saturate();
    do_reset(); sel = 2'b01; tgt = 8'd5;
    for (int i = 0; i < 4; i++) pair(1, 1'b0);
    check(lock_o, 1'b0, "R6 four of five good");
    pair(1, 1'b0);
    check(lock_o, 1'b1, "R6 fifth good locks");
    for (int i = 0; i < 5; i++) pair(1, 1'b0);
    tgt = 8'd7;
    idle(2);
    check(lock_o, 1'b1, "R8 target change keeps lock");
    pair(1, 1'b0);
    check(lock_o, 1'b0, "R7 count saturated at old target");
    pair(1, 1'b0);
    check(lock_o, 1'b1, "R7 reaches raised target");
    pair(6, 1'b0);
    check(lock_o, 1'b0, "R4 violation clears lock");
    tgt = 8'd2;
    pair(1, 1'b0);
    check(lock_o, 1'b0, "R7 count cleared by violation");
    pair(1, 1'b0);
    check(lock_o, 1'b1, "R7 relock after clear");
  endtask

  task automatic t_zero_target();
    do_reset(); sel = 2'b00; tgt = 8'd0;
    pair(3, 1'b0);
    check(lock_o, 1'b0, "R6 bad with zero target");
    pair(1, 1'b1);
    check(lock_o, 1'b1, "R6 zero target locks on one good");
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_windows();
    t_timeout();
    t_slip();
    t_sel_change();
    t_saturate();
    t_zero_target();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule